// File: doc/BRIEF.md
# Synchronous Rectifier Gate Timing Tracker

This block decides when the synchronous-rectifier switch on the secondary of a flyback converter is switched on and off. Its inputs are single-cycle flags from external comparators on the transformer winding: a rising flag when the primary switch turns on, a falling flag when secondary conduction begins, and a dead-time flag when the winding voltage crosses the dead-time threshold after the rectifier is released. A bias-undervoltage flag and an external disable keep the gate off. All inputs are synchronous to the system clock, and every time value is counted in clock cycles.

After a falling flag, the gate turns on after a selectable delay. It stays on for a tracked number of cycles. After each cycle, the measured dead time (from gate release to the dead-time flag) is compared with a selectable target, and the tracked on-time moves one count toward that target. Several guard rules protect against unsafe operation. An on-time ratio clamp freezes the tracking for one cycle. A minimum-period limit ends the gate early. Jumps in pulse width or switching period restart the tracking. A too-short dead time blanks the gate for two cycles. Time settings given in nanoseconds are converted to clocks by rounding up, using the clock-frequency parameter (21.6 MHz by default).

Top module: `sr_gate_tracker`

## Requirements
- R1: After reset the gate is low and the tracked on-time equals the floor TON_MIN (16 clocks), so the first gate pulse is 16 clocks long when no limit applies.
- R2: The gate rises D clock edges after the edge that samples the falling flag, with D = 7, 5, 4, 3 for delay codes 00, 01, 10, 11.
- R3: The gate stays high for the tracked on-time. Dead time is the number of edges from the gate-release edge to the edge that samples the dead-time flag. That dead time is compared with the target (54, 44, 33, 22 clocks for codes 00, 01, 10, 11). If it is larger, the tracked value rises by one. If it is smaller, the value falls by one, but never below TON_MIN. If it is equal, the value holds.
- R4: The on-time never exceeds P + floor(P/16), where P is the previous gate pulse length. When this clamp cuts the tracked value, that cycle's dead time does not step the tracked value.
- R5: Pulse width is the number of edges from the rising-flag sample to the falling-flag sample. A width differing from the previous one by more than the limit (7, 11, 16, 20 clocks for codes 00, 01, 10, 11) resets the tracked value to TON_MIN before that cycle's gate. A difference equal to the limit does not.
- R6: The gate is low from the Nth edge after the rising-flag edge onward, where N is the 12-bit minimum-period input.
- R7: A dead time below the guard value (50, 39, 29, 18 clocks for codes 00, 01, 10, 11) produces no gate on the next two falling flags and resets the tracked value to TON_MIN. A dead time equal to the guard value is handled as normal.
- R8: A rise-to-rise period longer than Q + floor(Q/4), where Q is the previous period, resets the tracked value to TON_MIN for the cycle that this rising flag starts.
- R9: While the undervoltage flag or the disable input is high, no gate starts. If either is raised while the gate is high, the gate is low one edge later. Such a cut cycle does not change the tracked value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vtr_rise_i | input | 1 | Winding-voltage rising flag (primary turn-on), one cycle |
| vtr_fall_i | input | 1 | Winding-voltage falling flag (secondary conduction start), one cycle |
| dt_evt_i | input | 1 | Dead-time comparator flag, one cycle |
| uv_i | input | 1 | Gate-driver bias undervoltage |
| sr_dis_i | input | 1 | External disable (transition or light load) |
| dly_sel_i | input | 2 | Turn-on delay code |
| pwl_sel_i | input | 2 | Pulse-width jump limit code |
| grd_sel_i | input | 2 | Dead-time guard code |
| tgt_sel_i | input | 2 | Dead-time target code |
| min_period_i | input | 12 | Minimum-period limit in clocks |
| gate_o | output | 1 | Synchronous-rectifier gate command |

## Verification
Each gate pulse begins D edges after the falling-flag edge and lasts exactly the on-time, so the bench counts low and then high samples taken on the falling clock edge. Those counts are the delay and the on-time. The dead-time flag is driven so that it is sampled exactly the chosen number of edges after the release edge. A tracking step, clamp, or reset is visible only in the next gate pulse, so each expected value is checked one cycle after the stimulus that causes it. A disable is checked on the sample right after the edge that captures it.

// File: rtl/sr_trk_pkg.sv
package sr_trk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_ON    = 2'd2,
        ST_OFF   = 2'd3
    } sr_state_e;

    // Nanoseconds to whole clock cycles, rounded up.
    function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned khz);
        return (ns * khz + 999_999) / 1_000_000;
    endfunction

endpackage

// File: rtl/sr_trk_decode.sv
module sr_trk_decode
    import sr_trk_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 21600,
    parameter int unsigned CFG_W   = 8
) (
    input  logic [1:0]       dly_sel_i,
    input  logic [1:0]       pwl_sel_i,
    input  logic [1:0]       grd_sel_i,
    input  logic [1:0]       tgt_sel_i,
    output logic [CFG_W-1:0] dly_clk_o,
    output logic [CFG_W-1:0] pwl_clk_o,
    output logic [CFG_W-1:0] grd_clk_o,
    output logic [CFG_W-1:0] tgt_clk_o
);

    logic [CFG_W-1:0] dly_lut [4];
    logic [CFG_W-1:0] pwl_lut [4];
    logic [CFG_W-1:0] grd_lut [4];
    logic [CFG_W-1:0] tgt_lut [4];

    // Each table is linear in its code, so it is computed, not listed.
    for (genvar g = 0; g < 4; g++) begin : g_lut
        assign dly_lut[g] = CFG_W'(ns_to_clk(280  - 50  * g, CLK_KHZ));
        assign pwl_lut[g] = CFG_W'(ns_to_clk(300  + 200 * g, CLK_KHZ));
        assign grd_lut[g] = CFG_W'(ns_to_clk(2300 - 500 * g, CLK_KHZ));
        assign tgt_lut[g] = CFG_W'(ns_to_clk(2500 - 500 * g, CLK_KHZ));
    end

    assign dly_clk_o = dly_lut[dly_sel_i];
    assign pwl_clk_o = pwl_lut[pwl_sel_i];
    assign grd_clk_o = grd_lut[grd_sel_i];
    assign tgt_clk_o = tgt_lut[tgt_sel_i];

endmodule

// File: rtl/sr_trk_meas.sv
module sr_trk_meas #(
    parameter int unsigned CNT_W = 13,
    parameter int unsigned CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic [CFG_W-1:0] pwl_clk_i,
    output logic [CNT_W-1:0] since_rise_o,
    output logic             jump_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] since;
        logic [CNT_W-1:0] pw_prev;
        logic [CNT_W-1:0] per_prev;
        logic             seen;
        logic             pw_ok;
        logic             per_ok;
    } meas_t;

    meas_t r_q, r_d;
    logic [CNT_W-1:0] pw_diff;
    logic [CNT_W:0]   per_lim;
    logic             pw_jump, per_jump;

    always_comb begin
        pw_diff  = (r_q.since >= r_q.pw_prev) ? (r_q.since - r_q.pw_prev)
                                              : (r_q.pw_prev - r_q.since);
        per_lim  = {1'b0, r_q.per_prev} + {3'b000, r_q.per_prev[CNT_W-1:2]};
        pw_jump  = fall_i && r_q.pw_ok &&
                   (pw_diff > {{(CNT_W-CFG_W){1'b0}}, pwl_clk_i});
        per_jump = rise_i && r_q.per_ok && ({1'b0, r_q.since} > per_lim);

        r_d = r_q;
        if (r_q.since != CNT_MAX) r_d.since = r_q.since + 1'b1;
        if (rise_i) begin
            r_d.since    = CNT_W'(1);
            r_d.per_prev = r_q.since;
            r_d.per_ok   = r_q.seen;
            r_d.seen     = 1'b1;
        end
        if (fall_i && r_q.seen) begin
            r_d.pw_prev = r_q.since;
            r_d.pw_ok   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign since_rise_o = r_q.since;
    assign jump_o       = pw_jump | per_jump;

    // R8: a rising flag always restarts the since-rise count.
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> (since_rise_o == CNT_W'(1)));

endmodule

// File: rtl/sr_gate_tracker.sv
module sr_gate_tracker
    import sr_trk_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 21600,
    parameter int unsigned TRK_W   = 10,
    parameter int unsigned TON_MIN = 16,
    parameter int unsigned CNT_W   = 13,
    parameter int unsigned MINP_W  = 12,
    parameter int unsigned CFG_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vtr_rise_i,
    input  logic              vtr_fall_i,
    input  logic              dt_evt_i,
    input  logic              uv_i,
    input  logic              sr_dis_i,
    input  logic [1:0]        dly_sel_i,
    input  logic [1:0]        pwl_sel_i,
    input  logic [1:0]        grd_sel_i,
    input  logic [1:0]        tgt_sel_i,
    input  logic [MINP_W-1:0] min_period_i,
    output logic              gate_o
);

    localparam logic [TRK_W-1:0] TRK_FLOOR = TRK_W'(TON_MIN);
    localparam logic [TRK_W-1:0] TRK_MAX   = {TRK_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam int unsigned      TPAD      = TRK_W - CFG_W;
    localparam int unsigned      CPAD      = CNT_W - CFG_W;
    localparam int unsigned      MPAD      = CNT_W - MINP_W;

    typedef struct packed {
        sr_state_e        state;
        logic [TRK_W-1:0] cnt;
        logic [TRK_W-1:0] ton_tgt;
        logic             freeze;
        logic [TRK_W-1:0] prev_on;
        logic [TRK_W-1:0] track;
        logic [1:0]       skip;
        logic [CNT_W-1:0] dead;
    } trk_t;

    localparam trk_t RST_VAL = '{
        state:   ST_IDLE,
        cnt:     '0,
        ton_tgt: '0,
        freeze:  1'b0,
        prev_on: TRK_MAX,
        track:   TRK_FLOOR,
        skip:    2'd0,
        dead:    '0
    };

    logic [CFG_W-1:0] dly_clk, pwl_clk, grd_clk, tgt_clk;
    logic [CNT_W-1:0] since_rise;
    logic             trk_jump;

    sr_trk_decode #(.CLK_KHZ(CLK_KHZ), .CFG_W(CFG_W)) u_dec (
        .dly_sel_i (dly_sel_i),
        .pwl_sel_i (pwl_sel_i),
        .grd_sel_i (grd_sel_i),
        .tgt_sel_i (tgt_sel_i),
        .dly_clk_o (dly_clk),
        .pwl_clk_o (pwl_clk),
        .grd_clk_o (grd_clk),
        .tgt_clk_o (tgt_clk)
    );

    sr_trk_meas #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_meas (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise_i       (vtr_rise_i),
        .fall_i       (vtr_fall_i),
        .pwl_clk_i    (pwl_clk),
        .since_rise_o (since_rise),
        .jump_o       (trk_jump)
    );

    trk_t             r_q, r_d;
    logic             blocked, per_hit;
    logic [TRK_W:0]   ratio_lim;
    logic [TRK_W-1:0] eff_trk;
    logic [CNT_W-1:0] minp_ext, grd_ext, tgt_ext;

    always_comb begin
        blocked   = uv_i | sr_dis_i;
        minp_ext  = {{MPAD{1'b0}}, min_period_i};
        grd_ext   = {{CPAD{1'b0}}, grd_clk};
        tgt_ext   = {{CPAD{1'b0}}, tgt_clk};
        per_hit   = (since_rise >= minp_ext);
        ratio_lim = {1'b0, r_q.prev_on} + {5'b00000, r_q.prev_on[TRK_W-1:4]};
        eff_trk   = trk_jump ? TRK_FLOOR : r_q.track;

        r_d = r_q;
        if (trk_jump) r_d.track = TRK_FLOOR;

        unique case (r_q.state)
            ST_IDLE: begin
                if (vtr_fall_i && !blocked) begin
                    if (r_q.skip != 2'd0) begin
                        r_d.skip = r_q.skip - 2'd1;
                    end else begin
                        r_d.state = ST_DELAY;
                        r_d.cnt   = TRK_W'(1);
                    end
                end
            end
            ST_DELAY: begin
                if (blocked) begin
                    r_d.state = ST_IDLE;
                end else if (r_q.cnt >= {{TPAD{1'b0}}, dly_clk}) begin
                    if (per_hit) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_ON;
                        r_d.cnt   = TRK_W'(1);
                        if ({1'b0, eff_trk} > ratio_lim) begin
                            r_d.ton_tgt = ratio_lim[TRK_W-1:0];
                            r_d.freeze  = 1'b1;
                        end else begin
                            r_d.ton_tgt = eff_trk;
                            r_d.freeze  = 1'b0;
                        end
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_ON: begin
                if (blocked) begin
                    r_d.state = ST_IDLE;
                end else if (r_q.cnt >= r_q.ton_tgt || per_hit) begin
                    r_d.state   = ST_OFF;
                    r_d.prev_on = r_q.cnt;
                    r_d.dead    = CNT_W'(1);
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_OFF: begin
                if (dt_evt_i) begin
                    r_d.state = ST_IDLE;
                    if (r_q.dead < grd_ext) begin
                        r_d.skip  = 2'd2;
                        r_d.track = TRK_FLOOR;
                    end else if (!r_q.freeze) begin
                        if (r_q.dead > tgt_ext && eff_trk != TRK_MAX)
                            r_d.track = eff_trk + 1'b1;
                        else if (r_q.dead < tgt_ext && eff_trk > TRK_FLOOR)
                            r_d.track = eff_trk - 1'b1;
                    end
                end else if (vtr_rise_i || vtr_fall_i) begin
                    r_d.state = ST_IDLE;
                end else if (r_q.dead != CNT_MAX) begin
                    r_d.dead = r_q.dead + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign gate_o = (r_q.state == ST_ON);

    // R9: a blocking input clears the gate by the next edge.
    a_r9_block: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_i || sr_dis_i) |=> !gate_o);

    // R2: the gate only starts out of the delay phase.
    a_r2_from_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(r_q.state == ST_DELAY));

    // R6: a high gate never outlives the minimum-period window.
    a_r6_min_period: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (since_rise <= minp_ext));

    // R7: no gate while blanking cycles remain.
    a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (r_q.skip == 2'd0));

    // R3: the tracked value never drops below its floor.
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.track >= TRK_FLOOR);

endmodule

// File: tb/tb_sr_gate_tracker.sv
module tb_sr_gate_tracker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rise = 1'b0, fall = 1'b0, dt = 1'b0, uv = 1'b0, dis = 1'b0;
    logic [1:0]  dly_sel = 2'd0, pwl_sel = 2'd0, grd_sel = 2'd3, tgt_sel = 2'd3;
    logic [11:0] minp = 12'd4095;
    logic        gate;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_gate_tracker dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .vtr_rise_i   (rise),
        .vtr_fall_i   (fall),
        .dt_evt_i     (dt),
        .uv_i         (uv),
        .sr_dis_i     (dis),
        .dly_sel_i    (dly_sel),
        .pwl_sel_i    (pwl_sel),
        .grd_sel_i    (grd_sel),
        .tgt_sel_i    (tgt_sel),
        .min_period_i (minp),
        .gate_o       (gate)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One switching cycle; entered and left on a falling clock edge.
    task automatic do_cycle(input int pw, input int dead, input int gap,
                            output int dly, output int ton);
        rise = 1'b1; @(negedge clk); rise = 1'b0;
        repeat (pw - 1) @(negedge clk);
        fall = 1'b1; @(negedge clk); fall = 1'b0;
        dly = 0;
        while (!gate && dly < 40) begin dly++; @(negedge clk); end
        ton = 0;
        while (gate) begin ton++; @(negedge clk); end
        if (ton > 0) begin
            repeat (dead - 1) @(negedge clk);
            dt = 1'b1; @(negedge clk); dt = 1'b0;
        end
        repeat (gap) @(negedge clk);
    endtask

    task automatic run_seq(input string tag, input int pw, input int dead,
                           input int n, input int first_ton, input int step);
        int d, t;
        for (int i = 0; i < n; i++) begin
            do_cycle(pw, dead, 5, d, t);
            chk(tag, t, first_ton + i * step);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 gate low after reset", int'(gate), 0);
    endtask

    task automatic t_delay;
        int exp_d [4] = '{7, 5, 4, 3};
        int d, t;
        for (int c = 0; c < 4; c++) begin
            dly_sel = 2'(c);
            do_cycle(20, 22, 5, d, t);
            chk("R2 turn-on delay", d, exp_d[c]);
            chk("R1 R3 on-time held at floor", t, 16);
        end
        dly_sel = 2'd3;
    endtask

    task automatic t_track;
        run_seq("R3 step up", 20, 27, 3, 16, 1);
        run_seq("R3 step down", 20, 19, 2, 19, -1);
    endtask

    task automatic t_clamp;
        int d, t;
        run_seq("R3 regrow", 20, 27, 3, 17, 1);
        minp = 12'd39;
        do_cycle(20, 27, 5, d, t);
        chk("R6 min-period cut", t, 16);
        minp = 12'd4095;
        run_seq("R4 ratio clamp with frozen tracking", 20, 19, 5, 17, 1);
        do_cycle(20, 19, 5, d, t);
        chk("R4 tracking resumes after clamp", t, 20);
    endtask

    task automatic t_pw;
        int d, t;
        do_cycle(27, 22, 5, d, t);
        chk("R5 width change at limit keeps track", t, 19);
        do_cycle(35, 22, 5, d, t);
        chk("R5 width jump resets track", t, 16);
        do_cycle(20, 22, 5, d, t);
        chk("R5 width jump back", t, 16);
    endtask

    task automatic t_floor;
        run_seq("R3 floor holds", 20, 19, 2, 16, 0);
    endtask

    task automatic t_period;
        int d, t;
        run_seq("R8 grow", 20, 27, 2, 16, 1);
        do_cycle(20, 27, 80, d, t);
        chk("R8 before long period", t, 18);
        do_cycle(20, 22, 5, d, t);
        chk("R8 long period resets track", t, 16);
    endtask

    task automatic t_guard;
        int d, t;
        run_seq("R7 grow", 20, 27, 2, 16, 1);
        do_cycle(20, 18, 5, d, t);
        chk("R7 dead equal to guard", t, 18);
        do_cycle(20, 10, 5, d, t);
        chk("R7 gate present before short dead time", t, 17);
        for (int i = 0; i < 2; i++) begin
            do_cycle(20, 22, 5, d, t);
            chk("R7 blanked cycle", t, 0);
        end
        do_cycle(20, 22, 5, d, t);
        chk("R7 gate back after two blanks", t, 16);
        chk("R7 delay after blanking", d, 3);
    endtask

    task automatic t_block;
        int d, t, k;
        uv = 1'b1;
        do_cycle(20, 22, 5, d, t);
        chk("R9 no gate under undervoltage", t, 0);
        uv = 1'b0;
        rise = 1'b1; @(negedge clk); rise = 1'b0;
        repeat (19) @(negedge clk);
        fall = 1'b1; @(negedge clk); fall = 1'b0;
        k = 0;
        while (!gate && k < 40) begin k++; @(negedge clk); end
        chk("R9 gate started before disable", int'(gate), 1);
        @(negedge clk);
        dis = 1'b1;
        @(negedge clk);
        chk("R9 disable drops gate next edge", int'(gate), 0);
        dis = 1'b0;
        repeat (40) @(negedge clk);
        do_cycle(20, 22, 5, d, t);
        chk("R9 track unchanged by cut cycle", t, 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_delay();
        t_track();
        t_clamp();
        t_pw();
        t_floor();
        t_period();
        t_guard();
        t_block();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule